// File: doc/BRIEF.md
# Direct Tap Phase Shift Controller

This block tracks and steers a phase-shift delay line built from discrete taps. The amount of delay is kept as a tap count, with no analog behaviour modelled. The count can be moved in two ways. The first is a relative step: the caller raises an enable for one cycle and selects increment or decrement. The second is an absolute target: the caller writes a 10-bit tap value, and the block walks the count to that value over a number of adjustment cycles. Each completed operation is acknowledged with a one-cycle done pulse.

The delay line covers one input clock period. That period is supplied at run time as a tap count. When a step would carry the count past the period boundary, the count wraps around. A build-time parameter sets whether each relative step moves one tap or eight taps. Before the walk begins, a target is first reduced modulo the period by repeated subtraction. The walk then moves one tap per cycle in the direction of the target, and it never crosses the wrap point. A busy output stays high for the whole of an operation, and any request that arrives while it is high is dropped.

Top module: `tap_phase_ctrl`

## Requirements
- R1: After reset, tap_o is 0, busy_o is 0 and ps_done_o is 0.
- R2: Each relative step changes the count by 1 tap when parameter STEP_BY_ONE is 1, and by 8 taps when STEP_BY_ONE is 0.
- R3: ps_en_i=1 is sampled at an edge while idle, with ps_inc_i=1 for increment and 0 for decrement. busy_o is then 1 for one cycle. At the next edge, tap_o takes its new value, busy_o returns to 0 and ps_done_o is 1 for exactly one cycle.
- R4: An increment whose result would be at or above period_i gives tap + step − period_i.
- R5: A decrement from a count below the step size gives tap + period_i − step. From 0 this is period_i − step.
- R6: tgt_we_i=1 while idle loads tgt_i (0 to 1023). The operation ends with tap_o equal to tgt_i mod period_i and a one-cycle ps_done_o.
- R7: Let q = floor(tgt_i / period_i) and d = |tap − (tgt_i mod period_i)|. ps_done_o rises at the (q + d + 2)-th edge after the write edge. A target equal to the current count finishes after 2 edges.
- R8: While busy_o is 1, ps_en_i and tgt_we_i have no effect. No extra done pulse is produced and the final count is unchanged.
- R9: When tgt_we_i and ps_en_i are both 1 in the same idle cycle, the target write is taken and the step is dropped.
- R10: period_i must be greater than the step size and at most 1024, and must stay stable while busy_o is 1. Whenever the block is idle, tap_o is below period_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | TAP_W+1 | Input clock period expressed in taps |
| ps_en_i | input | 1 | Relative step request, one cycle |
| ps_inc_i | input | 1 | Step direction: 1 increment, 0 decrement |
| ps_done_o | output | 1 | One-cycle completion pulse |
| tgt_we_i | input | 1 | Absolute target write strobe |
| tgt_i | input | TAP_W | Absolute target tap value |
| tap_o | output | TAP_W | Current inserted tap count |
| busy_o | output | 1 | Operation in progress |

## Verification
The hardest case to reach is a request that arrives in the middle of an absolute walk. To get there, the stimulus writes a target far from the current count, so the walk runs for dozens of cycles. A few cycles later, while busy_o is still high, it pulses both the step enable and a conflicting target together. The scoreboard expects only the first target's result, at its predicted cycle. Two instances run side by side, one with 1-tap steps and one with 8-tap steps. Their counts drift apart, so a single sequence drives both across the wrap point from different positions and with different walk lengths.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STEP   = 2'd1,
    ST_REDUCE = 2'd2,
    ST_SEEK   = 2'd3
  } tps_state_e;
endpackage

// File: rtl/tps_wrap_step.sv
`timescale 1ns/1ps
// Next tap for a relative step, wrapping at the period boundary.
module tps_wrap_step #(
  parameter int TAP_W = 10,
  parameter int STEP  = 1
) (
  input  logic [TAP_W-1:0] tap_i,
  input  logic [TAP_W:0]   period_i,
  input  logic             inc_i,
  output logic [TAP_W-1:0] next_o
);
  localparam int W = TAP_W + 2;
  localparam logic [W-1:0] STEP_W = W'(STEP);

  logic [W-1:0] tap_w, per_w, up, dn, res;

  assign tap_w = {2'b00, tap_i};
  assign per_w = {1'b0, period_i};

  always_comb begin
    up = tap_w + STEP_W;
    if (up >= per_w) up = up - per_w;
    if (tap_w >= STEP_W) dn = tap_w - STEP_W;
    else                 dn = tap_w + per_w - STEP_W;
    res = inc_i ? up : dn;
  end

  assign next_o = res[TAP_W-1:0];
endmodule

// File: rtl/tps_target_mod.sv
`timescale 1ns/1ps
// Iterative modulo: one subtraction of the period per cycle.
module tps_target_mod #(
  parameter int TAP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TAP_W-1:0] value_i,
  input  logic [TAP_W:0]   period_i,
  output logic [TAP_W-1:0] rem_o,
  output logic             ready_o
);
  logic [TAP_W-1:0] rem_q;
  logic             act_q;

  assign ready_o = act_q && ({1'b0, rem_q} < period_i);
  assign rem_o   = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      rem_q <= value_i;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (ready_o) act_q <= 1'b0;
      else         rem_q <= rem_q - period_i[TAP_W-1:0];
    end
  end
endmodule

// File: rtl/tap_phase_ctrl.sv
`timescale 1ns/1ps
module tap_phase_ctrl
  import tps_pkg::*;
#(
  parameter int TAP_W       = 10,
  parameter bit STEP_BY_ONE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W:0]   period_i,
  input  logic             ps_en_i,
  input  logic             ps_inc_i,
  output logic             ps_done_o,
  input  logic             tgt_we_i,
  input  logic [TAP_W-1:0] tgt_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             busy_o
);
  localparam int STEP = STEP_BY_ONE ? 1 : 8;

  tps_state_e       state_q;
  logic [TAP_W-1:0] tap_q;
  logic             dir_q;
  logic             done_q;
  logic [TAP_W-1:0] step_nxt;
  logic [TAP_W-1:0] seek_tgt;
  logic             red_ready;
  logic             red_load;

  // Target write wins over a step in the same idle cycle.
  assign red_load = (state_q == ST_IDLE) && tgt_we_i;

  tps_wrap_step #(.TAP_W(TAP_W), .STEP(STEP)) u_step (
    .tap_i   (tap_q),
    .period_i(period_i),
    .inc_i   (dir_q),
    .next_o  (step_nxt)
  );

  tps_target_mod #(.TAP_W(TAP_W)) u_mod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (red_load),
    .value_i (tgt_i),
    .period_i(period_i),
    .rem_o   (seek_tgt),
    .ready_o (red_ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tgt_we_i) begin
            state_q <= ST_REDUCE;
          end else if (ps_en_i) begin
            state_q <= ST_STEP;
            dir_q   <= ps_inc_i;
          end
        end
        ST_STEP: begin
          tap_q   <= step_nxt;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_REDUCE: begin
          if (red_ready) state_q <= ST_SEEK;
        end
        ST_SEEK: begin
          if (tap_q == seek_tgt) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (tap_q < seek_tgt) begin
            tap_q <= tap_q + 1'b1;
          end else begin
            tap_q <= tap_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tap_o     = tap_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign ps_done_o = done_q;
endmodule

// File: rtl/tps_checker.sv
`timescale 1ns/1ps
module tps_checker #(
  parameter int TAP_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TAP_W:0]   period_i,
  input logic             ps_done_o,
  input logic [TAP_W-1:0] tap_o,
  input logic             busy_o
);
  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_done_o |=> !ps_done_o);

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_done_o |-> !busy_o);

  // R6
  done_after_work_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_done_o |-> $past(busy_o));

  // R8
  tap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> $stable(tap_o));

  // R10
  tap_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ({1'b0, tap_o} < period_i));
endmodule

bind tap_phase_ctrl tps_checker #(.TAP_W(TAP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .period_i (period_i),
  .ps_done_o(ps_done_o),
  .tap_o    (tap_o),
  .busy_o   (busy_o)
);

// File: tb/tb_tap_phase_ctrl.sv
`timescale 1ns/1ps
module tb_tap_phase_ctrl;
  localparam int TAP_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [TAP_W:0]   period = 11'd1000;
  logic             ps_en = 1'b0, ps_inc = 1'b0, tgt_we = 1'b0;
  logic [TAP_W-1:0] tgt = '0;
  logic             done_f, done_c, busy_f, busy_c;
  logic [TAP_W-1:0] tap_f, tap_c;

  tap_phase_ctrl #(.TAP_W(TAP_W), .STEP_BY_ONE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .ps_en_i(ps_en),
    .ps_inc_i(ps_inc), .ps_done_o(done_f), .tgt_we_i(tgt_we), .tgt_i(tgt),
    .tap_o(tap_f), .busy_o(busy_f));

  tap_phase_ctrl #(.TAP_W(TAP_W), .STEP_BY_ONE(1'b0)) dut_c (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .ps_en_i(ps_en),
    .ps_inc_i(ps_inc), .ps_done_o(done_c), .tgt_we_i(tgt_we), .tgt_i(tgt),
    .tap_o(tap_c), .busy_o(busy_c));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0, n_bad = 0;
  int per = 1000, mf = 0, mc = 0;

  typedef struct {int tap; int cyc; string req;} exp_t;
  exp_t q_f[$], q_c[$];
  exp_t ef, ec;

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap_step(int t, int s, bit inc);
    int n;
    if (inc) begin
      n = t + s;
      if (n >= per) n = n - per;
    end else if (t >= s) n = t - s;
    else n = t + per - s;
    return n;
  endfunction

  function automatic int seek_lat(int from, int t);
    int tm, d;
    tm = t % per;
    d = (from > tm) ? from - tm : tm - from;
    return t / per + d + 2;
  endfunction

  // Driver side of the scoreboard: expected tap and done edge per instance.
  task automatic push_target(int t, string req, int base);
    q_f.push_back('{t % per, base + 1 + seek_lat(mf, t), req});
    q_c.push_back('{t % per, base + 1 + seek_lat(mc, t), req});
    mf = t % per;
    mc = t % per;
  endtask

  task automatic push_step(bit inc, string req, int base);
    mf = wrap_step(mf, 1, inc);
    mc = wrap_step(mc, 8, inc);
    q_f.push_back('{mf, base + 2, req});
    q_c.push_back('{mc, base + 2, req});
  endtask

  task automatic issue(bit do_tgt, int t, bit do_ps, bit inc, int noise, string req);
    int base;
    @(negedge clk);
    base = cyc;
    tgt_we = do_tgt; tgt = TAP_W'(t); ps_en = do_ps; ps_inc = inc;
    if (do_tgt) push_target(t, req, base);
    else if (do_ps) push_step(inc, req, base);
    @(negedge clk);
    tgt_we = 1'b0; ps_en = 1'b0;
    if (!do_tgt && do_ps) begin
      chk("R3", "fine busy during step", int'(busy_f), 1);
      chk("R3", "coarse busy during step", int'(busy_c), 1);
    end
    if (noise >= 0) begin
      repeat (noise) @(negedge clk);
      chk("R8", "fine busy at noise", int'(busy_f), 1);
      chk("R8", "coarse busy at noise", int'(busy_c), 1);
      ps_en = 1'b1; ps_inc = 1'b1; tgt_we = 1'b1; tgt = 10'd500;
      @(negedge clk);
      ps_en = 1'b0; tgt_we = 1'b0;
    end
    while (busy_f || busy_c) @(negedge clk);
    @(negedge clk);
    chk(req, "fine result pending", q_f.size(), 0);
    chk(req, "coarse result pending", q_c.size(), 0);
    chk("R10", "fine tap below period", int'(int'(tap_f) < per), 1);
    chk("R10", "coarse tap below period", int'(int'(tap_c) < per), 1);
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_f) begin
        if (q_f.size() == 0) chk("R8", "fine unexpected done", 1, 0);
        else begin
          ef = q_f.pop_front();
          chk(ef.req, "fine tap", int'(tap_f), ef.tap);
          chk(ef.req, "fine done edge", cyc, ef.cyc);
        end
      end
      if (done_c) begin
        if (q_c.size() == 0) chk("R8", "coarse unexpected done", 1, 0);
        else begin
          ec = q_c.pop_front();
          chk(ec.req, "coarse tap", int'(tap_c), ec.tap);
          chk(ec.req, "coarse done edge", cyc, ec.cyc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "fine tap in reset", int'(tap_f), 0);
    chk("R1", "fine busy in reset", int'(busy_f), 0);
    chk("R1", "coarse done in reset", int'(done_c), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fine tap after reset", int'(tap_f), 0);
    chk("R1", "coarse tap after reset", int'(tap_c), 0);
    chk("R1", "fine done after reset", int'(done_f), 0);

    issue(1'b0, 0, 1'b1, 1'b1, -1, "R2");   // 1 / 8
    issue(1'b0, 0, 1'b1, 1'b0, -1, "R3");   // 0 / 0
    issue(1'b0, 0, 1'b1, 1'b0, -1, "R5");   // 999 / 992
    issue(1'b1, 1023, 1'b0, 1'b0, -1, "R6"); // 23
    issue(1'b1, 998, 1'b0, 1'b0, -1, "R7");
    issue(1'b0, 0, 1'b1, 1'b1, -1, "R4");   // 999 / 6
    issue(1'b0, 0, 1'b1, 1'b1, -1, "R4");   // 0 / 14
    issue(1'b1, 0, 1'b0, 1'b0, -1, "R7");

    @(negedge clk);
    period = 11'd100; per = 100;
    issue(1'b1, 250, 1'b0, 1'b0, -1, "R6"); // 50
    issue(1'b1, 99, 1'b0, 1'b0, -1, "R6");
    issue(1'b0, 0, 1'b1, 1'b1, -1, "R4");   // 0 / 7
    issue(1'b1, 90, 1'b0, 1'b0, 3, "R8");
    issue(1'b1, 40, 1'b1, 1'b1, -1, "R9");
    issue(1'b1, 40, 1'b0, 1'b0, -1, "R7");  // same target, 2 edges
    issue(1'b1, 3, 1'b0, 1'b0, -1, "R6");
    issue(1'b0, 0, 1'b1, 1'b0, -1, "R5");   // 2 / 95

    repeat (4) @(negedge clk);
    chk("R8", "fine leftover items", q_f.size(), 0);
    chk("R8", "coarse leftover items", q_c.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule